// File: doc/BRIEF.md
# Cache Miss FIFO Link Requester

This block connects a data cache controller to two one-way FIFO links. The outbound link carries request words and the inbound link returns fill data. The cache side presents one request at a time, either a read miss or a write. The requester turns that request into a short stream of 32-bit words, each paired with one control bit. It pushes the words out under the outbound full flag. For a read miss, it then drains the returned line words under the inbound exists flag.

A read miss produces a single word, the line-aligned address, with control bit 0. A write produces three words in a fixed order: the address word with control bit 1, the write data, and a byte-mask word. For writes, the two low bits of the address word carry the lane offset that matches the access size. The request type therefore needs no separate command wire.

States: `ST_IDLE`, `ST_ADDR` (address word due), `ST_DATA` (write data due), `ST_MASK` (byte-mask word due) and `ST_FILL` (collecting the line). Transitions:
- idle-accept: `ST_IDLE` to `ST_ADDR`.
- read-issued: `ST_ADDR` to `ST_FILL`.
- write-issued: `ST_ADDR` to `ST_DATA`.
- data-sent: `ST_DATA` to `ST_MASK`.
- mask-sent: `ST_MASK` to `ST_IDLE`.
- line-complete: `ST_FILL` to `ST_IDLE`.

Every due state loops on itself while the word is blocked.

Top module: `miss_link_req`

## Requirements
- R1: A synchronous active-high `rst` puts the requester in idle. In the cycle after a reset edge, `out_wr`, `in_rd` and `busy` are low and `req_ready` is high.
- R2: A request is accepted only on a rising edge where `req_valid` is high and the requester is idle (`req_ready` high). `busy` is high from the next cycle on. A `req_valid` raised while busy is dropped: it sends no word and starts no later transaction.
- R3: A read miss (`req_write`=0) sends exactly one word. That word is `req_addr` with its low log2(LINE_WORDS)+2 bits cleared (bits [3:0] for a 4-word line), and its control bit is 0.
- R4: A write (`req_write`=1) sends exactly three words in order: the address word with control bit 1, then `req_wdata` with control bit 0, then the byte-mask word with control bit 0. The mask word carries the mask in bits [3:0] and zeros above.
- R5: The byte mask and the address word's bits [1:0] depend on `req_size` and `req_addr[1:0]`. Lane n is data bits [8n+7:8n].
  - Size 0 (byte): mask is 1 shifted left by `req_addr[1:0]`, and bits [1:0] are `req_addr[1:0]`.
  - Size 1 (halfword): mask is 4'b1100 when `req_addr[1]` is 1 and 4'b0011 otherwise, and bits [1:0] are {`req_addr[1]`,0}.
  - Size 2 or 3 (word): mask is 4'b1111 and bits [1:0] are 00.
- R6: With CHECK_FULL=1, `out_wr` is high only in a cycle where `out_full` is low.
- R7: While a word is due but blocked by `out_full`, `out_data` and `out_ctrl` hold that word unchanged. The word is sent exactly once when `out_full` drops.
- R8: In `ST_FILL`, `in_rd` equals `in_exists`, and `in_rd` is never high outside `ST_FILL`. Each read presents `in_data` on `fill_word` with `fill_word_valid` high. `fill_idx` counts 0 to LINE_WORDS-1 in arrival order.
- R9: `fill_done` is high exactly with the last line word's read. `busy` is low in the following cycle.
- R10: For a write, `busy` stays high until the cycle in which the mask word is written, and is low in the next cycle.
- R11: With CHECK_FULL=0, `out_full` is ignored. A due word is written in every cycle, so a write's three words go out in the three cycles after acceptance, even with `out_full` high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cache side presents a request |
| req_write | input | 1 | 1 = write, 0 = read miss |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Requester idle, request can be taken |
| busy | output | 1 | Transaction in progress |
| out_wr | output | 1 | Outbound link write strobe |
| out_data | output | 32 | Outbound word |
| out_ctrl | output | 1 | Outbound control bit |
| out_full | input | 1 | Outbound link cannot take a word |
| in_rd | output | 1 | Inbound link read strobe |
| in_data | input | 32 | Inbound word |
| in_exists | input | 1 | Inbound link holds a word |
| fill_word_valid | output | 1 | A line word is delivered this cycle |
| fill_word | output | 32 | Delivered line word |
| fill_idx | output | 2 | Position of the word within the line |
| fill_done | output | 1 | Last line word delivered |

## Verification
The hardest situation to reach from the ports is `out_full` rising in exactly the cycle a particular word becomes due, in each of `ST_ADDR`, `ST_DATA` and `ST_MASK`. The same applies to inbound gaps that split the line fill at every position. The bench drives `out_full` and `in_exists` from 16-bit patterns rotated once per clock. The patterns are chosen so their phase against each transaction walks across every due word and every fill index. A behavioural queue model predicts each strobe and word on every clock. A request raised while the outbound side is held full probes the drop-while-busy rule.

// File: rtl/mlr_pkg.sv
package mlr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_MASK,
        ST_FILL
    } mlr_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/mlr_encode.sv
module mlr_encode #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic              is_write,
    input  logic [1:0]        size,
    input  logic [WORD_W-1:0] addr,
    output logic [WORD_W-1:0] addr_word,
    output logic [3:0]        lane_mask
);
    import mlr_pkg::*;

    localparam int OFF_BITS = $clog2(LINE_WORDS) + 2;
    localparam logic [WORD_W-1:0] LINE_MASK = ~((WORD_W'(1) << OFF_BITS) - WORD_W'(1));

    logic [1:0] lane_lo;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                lane_mask = 4'b0001 << addr[1:0];
                lane_lo   = addr[1:0];
            end
            SZ_HALF: begin
                lane_mask = addr[1] ? 4'b1100 : 4'b0011;
                lane_lo   = {addr[1], 1'b0};
            end
            default: begin
                lane_mask = 4'b1111;
                lane_lo   = 2'b00;
            end
        endcase
    end

    always_comb begin
        if (is_write) begin
            addr_word = {addr[WORD_W-1:2], lane_lo};
        end else begin
            addr_word = addr & LINE_MASK;
        end
    end

endmodule

// File: rtl/mlr_fsm.sv
module mlr_fsm #(
    parameter int LINE_WORDS = 4,
    parameter bit CHECK_FULL = 1'b1,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  txn_write,
    input  logic                  out_full,
    input  logic                  in_exists,
    output mlr_pkg::mlr_state_e   state,
    output logic                  out_wr,
    output logic                  in_rd,
    output logic                  fill_done,
    output logic [IDX_W-1:0]      fill_idx,
    output logic                  busy,
    output logic                  send_phase
);
    import mlr_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS - 1);

    mlr_state_e       state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic             push_ok;
    logic             last_word;

    assign push_ok   = CHECK_FULL ? !out_full : 1'b1;
    assign last_word = (cnt_q == LAST_IDX);

    // state register and fill counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (in_rd) begin
                cnt_q <= last_word ? '0 : cnt_q + IDX_W'(1);
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)   state_d = ST_ADDR;
            ST_ADDR: if (push_ok) state_d = txn_write ? ST_DATA : ST_FILL;
            ST_DATA: if (push_ok) state_d = ST_MASK;
            ST_MASK: if (push_ok) state_d = ST_IDLE;
            ST_FILL: if (in_exists && last_word) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_wr     = 1'b0;
        in_rd      = 1'b0;
        send_phase = 1'b0;
        unique case (state_q)
            ST_ADDR, ST_DATA, ST_MASK: begin
                send_phase = 1'b1;
                out_wr     = push_ok;
            end
            ST_FILL: in_rd = in_exists;
            default: ;
        endcase
        fill_done = in_rd && last_word;
        busy      = (state_q != ST_IDLE);
    end

    assign state    = state_q;
    assign fill_idx = cnt_q;

endmodule

// File: rtl/miss_link_req.sv
module miss_link_req #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter bit CHECK_FULL = 1'b1,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              busy,
    output logic              out_wr,
    output logic [WORD_W-1:0] out_data,
    output logic              out_ctrl,
    input  logic              out_full,
    output logic              in_rd,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_exists,
    output logic              fill_word_valid,
    output logic [WORD_W-1:0] fill_word,
    output logic [IDX_W-1:0]  fill_idx,
    output logic              fill_done
);
    import mlr_pkg::*;

    mlr_state_e        state;
    logic              send_phase;
    logic              accept;
    logic [WORD_W-1:0] enc_addr;
    logic [3:0]        enc_mask;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic [3:0]        mask_q;
    logic              wr_q;

    assign accept = req_valid && req_ready;

    mlr_encode #(
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_encode (
        .is_write  (req_write),
        .size      (req_size),
        .addr      (req_addr),
        .addr_word (enc_addr),
        .lane_mask (enc_mask)
    );

    mlr_fsm #(
        .LINE_WORDS (LINE_WORDS),
        .CHECK_FULL (CHECK_FULL)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .txn_write  (wr_q),
        .out_full   (out_full),
        .in_exists  (in_exists),
        .state      (state),
        .out_wr     (out_wr),
        .in_rd      (in_rd),
        .fill_done  (fill_done),
        .fill_idx   (fill_idx),
        .busy       (busy),
        .send_phase (send_phase)
    );

    // request payload, captured once at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            mask_q <= '0;
            wr_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= enc_addr;
            data_q <= req_wdata;
            mask_q <= enc_mask;
            wr_q   <= req_write;
        end
    end

    // outbound word selection
    always_comb begin
        out_data = '0;
        out_ctrl = 1'b0;
        unique case (state)
            ST_ADDR: begin
                out_data = addr_q;
                out_ctrl = wr_q;
            end
            ST_DATA: out_data = data_q;
            ST_MASK: out_data = {{(WORD_W-4){1'b0}}, mask_q};
            default: ;
        endcase
    end

    assign req_ready       = !busy;
    assign fill_word       = in_data;
    assign fill_word_valid = in_rd;

endmodule

// File: rtl/mlr_sva.sv
module mlr_sva #(
    parameter int WORD_W     = 32,
    parameter bit CHECK_FULL = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              out_wr,
    input logic              out_full,
    input logic [WORD_W-1:0] out_data,
    input logic              out_ctrl,
    input logic              in_rd,
    input logic              in_exists,
    input logic              fill_done,
    input logic              tx_due
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_wr && !in_rd && !busy && req_ready)); // R1

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy); // R2

    AST_WR_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        (CHECK_FULL && out_wr) |-> !out_full); // R6

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (tx_due && !out_wr) |=> (tx_due && $stable(out_data) && $stable(out_ctrl))); // R7

    AST_RD_EXISTS: assert property (@(posedge clk) disable iff (rst)
        in_rd |-> in_exists); // R8

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(in_rd && tx_due)); // R8

    AST_DONE_FREES: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> !busy); // R9

endmodule

bind miss_link_req mlr_sva #(
    .WORD_W     (WORD_W),
    .CHECK_FULL (CHECK_FULL)
) u_mlr_sva (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .out_wr    (out_wr),
    .out_full  (out_full),
    .out_data  (out_data),
    .out_ctrl  (out_ctrl),
    .in_rd     (in_rd),
    .in_exists (in_exists),
    .fill_done (fill_done),
    .tx_due    (send_phase)
);

// File: tb/test_miss_link_req.sv
module test_miss_link_req;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, busy, out_wr, out_ctrl, in_rd;
    logic [31:0] out_data, in_data, fill_word;
    logic        out_full = 1'b0, in_exists = 1'b0;
    logic        fill_word_valid, fill_done;
    logic [1:0]  fill_idx;

    logic        nf_valid = 1'b0;
    logic        nf_ready, nf_busy, nf_wr, nf_ctrl, nf_rd, nf_fv, nf_done;
    logic [31:0] nf_data, nf_fword;
    logic [1:0]  nf_idx;

    miss_link_req i_miss_link_req (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .busy(busy), .out_wr(out_wr), .out_data(out_data),
        .out_ctrl(out_ctrl), .out_full(out_full), .in_rd(in_rd), .in_data(in_data),
        .in_exists(in_exists), .fill_word_valid(fill_word_valid),
        .fill_word(fill_word), .fill_idx(fill_idx), .fill_done(fill_done)
    );

    miss_link_req #(.CHECK_FULL(1'b0)) i_miss_link_req_nofull (
        .clk(clk), .rst(rst), .req_valid(nf_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(nf_ready), .busy(nf_busy), .out_wr(nf_wr), .out_data(nf_data),
        .out_ctrl(nf_ctrl), .out_full(1'b1), .in_rd(nf_rd), .in_data(32'h0),
        .in_exists(1'b0), .fill_word_valid(nf_fv),
        .fill_word(nf_fword), .fill_idx(nf_idx), .fill_done(nf_done)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // link pattern driver and inbound data source
    int          cyc = 0;
    int          src_idx = 0;
    logic        adv = 1'b0;
    logic [15:0] full_pat = '0;
    logic [15:0] ex_pat = '0;

    assign in_data = 32'hA500_0000 + 32'(src_idx);

    always @(posedge clk) begin
        #1;
        cyc++;
        out_full  = full_pat[cyc % 16];
        in_exists = ex_pat[cyc % 16];
        if (adv) src_idx++;
        if (cyc > WATCHDOG) begin
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected<%0d cycles", cyc, WATCHDOG);
            report();
        end
    end

    // behavioural reference model and observers
    typedef struct {
        logic [31:0] d;
        logic        c;
    } word_t;

    word_t       mq[$];
    word_t       obs[$];
    logic [31:0] got[$];
    bit          m_busy = 0, m_read = 0;
    int          m_cnt = 0;
    int          n_done = 0;

    function automatic logic [3:0] exp_mask(input logic [1:0] sz, input logic [31:0] a);
        if (sz == 2'd0) return 4'b0001 << a[1:0];
        if (sz == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [1:0] exp_lo(input logic [1:0] sz, input logic [31:0] a);
        if (sz == 2'd0) return a[1:0];
        if (sz == 2'd1) return {a[1], 1'b0};
        return 2'b00;
    endfunction

    always @(negedge clk) begin
        bit e_wr, e_rd;
        adv = in_rd;
        if (out_wr) obs.push_back('{out_data, out_ctrl});
        if (fill_word_valid) got.push_back(fill_word);
        if (fill_done) n_done++;
        if (rst) begin
            mq.delete();
            m_busy = 0; m_read = 0; m_cnt = 0;
        end else begin
            e_wr = m_busy && (mq.size() > 0) && !out_full;
            e_rd = m_busy && (mq.size() == 0) && m_read && in_exists;
            chk("R2",  "req_ready", 32'(req_ready), 32'(!m_busy));
            chk("R10", "busy",      32'(busy),      32'(m_busy));
            chk("R6",  "out_wr",    32'(out_wr),    32'(e_wr));
            if (m_busy && mq.size() > 0) begin
                chk("R7", "out_data", out_data,     mq[0].d);
                chk("R7", "out_ctrl", 32'(out_ctrl), 32'(mq[0].c));
            end
            chk("R8", "in_rd", 32'(in_rd), 32'(e_rd));
            if (e_rd) begin
                chk("R8", "fill_word", fill_word,     in_data);
                chk("R8", "fill_idx",  32'(fill_idx), 32'(m_cnt));
            end
            chk("R9", "fill_done", 32'(fill_done), 32'(e_rd && m_cnt == 3));
            if (!m_busy && req_valid) begin
                if (req_write) begin
                    mq.push_back('{{req_addr[31:2], exp_lo(req_size, req_addr)}, 1'b1});
                    mq.push_back('{req_wdata, 1'b0});
                    mq.push_back('{{28'h0, exp_mask(req_size, req_addr)}, 1'b0});
                end else begin
                    mq.push_back('{req_addr & 32'hFFFF_FFF0, 1'b0});
                end
                m_busy = 1; m_read = !req_write; m_cnt = 0;
            end else begin
                if (e_wr) begin
                    void'(mq.pop_front());
                    if (mq.size() == 0 && !m_read) m_busy = 0;
                end
                if (e_rd) begin
                    m_cnt++;
                    if (m_cnt == 4) begin
                        m_busy = 0; m_read = 0; m_cnt = 0;
                    end
                end
            end
        end
    end

    // stimulus
    task automatic issue(input logic wr, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic check_write(input string tag, input logic [31:0] aw,
                               input logic [31:0] d, input logic [3:0] m);
        chk(tag, "write word count", 32'(obs.size()), 32'd3);
        if (obs.size() == 3) begin
            chk(tag, "addr word",  obs[0].d, aw);
            chk(tag, "addr ctrl",  32'(obs[0].c), 32'd1);
            chk(tag, "data word",  obs[1].d, d);
            chk(tag, "data ctrl",  32'(obs[1].c), 32'd0);
            chk(tag, "mask word",  obs[2].d, {28'h0, m});
            chk(tag, "mask ctrl",  32'(obs[2].c), 32'd0);
        end
        obs.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: state right after reset
        chk("R1", "out_wr after reset",    32'(out_wr),    32'd0);
        chk("R1", "in_rd after reset",     32'(in_rd),     32'd0);
        chk("R1", "busy after reset",      32'(busy),      32'd0);
        chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);

        // R3 / R8 / R9: read miss with a gappy inbound link
        obs.delete(); got.delete(); n_done = 0;
        ex_pat = 16'b0110_1011_0010_1101;
        issue(1'b0, 2'd2, 32'h2000_0ABC, 32'h0);
        wait_idle();
        chk("R3", "read word count", 32'(obs.size()), 32'd1);
        if (obs.size() == 1) begin
            chk("R3", "read addr word", obs[0].d, 32'h2000_0AB0);
            chk("R3", "read ctrl",      32'(obs[0].c), 32'd0);
        end
        chk("R8", "line word count", 32'(got.size()), 32'd4);
        if (got.size() == 4)
            for (int i = 1; i < 4; i++)
                chk("R8", "line word order", got[i], got[0] + 32'(i));
        chk("R9", "done pulses", 32'(n_done), 32'd1);
        obs.delete();

        // R4 / R5: each size and lane offset
        issue(1'b1, 2'd0, 32'h1000_0006, 32'hDEAD_BEEF);
        wait_idle();
        check_write("R5", 32'h1000_0006, 32'hDEAD_BEEF, 4'b0100);
        issue(1'b1, 2'd1, 32'h1000_0012, 32'h1234_5678);
        wait_idle();
        check_write("R5", 32'h1000_0012, 32'h1234_5678, 4'b1100);
        issue(1'b1, 2'd1, 32'h1000_0031, 32'h0BAD_F00D);
        wait_idle();
        check_write("R5", 32'h1000_0030, 32'h0BAD_F00D, 4'b0011);
        issue(1'b1, 2'd2, 32'h1000_0043, 32'hCAFE_0001);
        wait_idle();
        check_write("R4", 32'h1000_0040, 32'hCAFE_0001, 4'b1111);

        // R7: outbound stalls at different phases
        full_pat = 16'b1110_0111_0011_1100;
        issue(1'b1, 2'd0, 32'h3000_0003, 32'h5555_AAAA);
        wait_idle();
        check_write("R7", 32'h3000_0003, 32'h5555_AAAA, 4'b1000);
        full_pat = 16'b0011_1001_1100_0111;
        issue(1'b1, 2'd2, 32'h3000_0100, 32'h0F0F_F0F0);
        wait_idle();
        check_write("R7", 32'h3000_0100, 32'h0F0F_F0F0, 4'b1111);
        got.delete(); n_done = 0;
        ex_pat = 16'b1000_0100_0010_0001;
        issue(1'b0, 2'd0, 32'h4000_007F, 32'h0);
        wait_idle();
        chk("R7", "stalled read words", 32'(obs.size()), 32'd1);
        chk("R9", "stalled read done",  32'(n_done), 32'd1);
        obs.delete();

        // R2: request while busy is dropped
        full_pat = 16'hFFFF;
        issue(1'b1, 2'd2, 32'h5000_0000, 32'h1111_2222);
        issue(1'b0, 2'd2, 32'h6000_0000, 32'h0);
        full_pat = 16'h0000;
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R2", "busy after dropped request", 32'(busy), 32'd0);
        check_write("R2", 32'h5000_0000, 32'h1111_2222, 4'b1111);

        // R11: variant that ignores the full flag
        @(posedge clk); #1;
        nf_valid = 1'b1; req_write = 1'b1; req_size = 2'd1;
        req_addr = 32'h7000_0002; req_wdata = 32'h7777_8888;
        @(posedge clk); #1;
        nf_valid = 1'b0;
        @(negedge clk);
        chk("R11", "addr written under full", 32'(nf_wr), 32'd1);
        chk("R11", "addr word", nf_data, 32'h7000_0002);
        chk("R11", "addr ctrl", 32'(nf_ctrl), 32'd1);
        @(negedge clk);
        chk("R11", "data written under full", 32'(nf_wr), 32'd1);
        chk("R11", "data word", nf_data, 32'h7777_8888);
        @(negedge clk);
        chk("R11", "mask written under full", 32'(nf_wr), 32'd1);
        chk("R11", "mask word", nf_data, 32'h0000_000C);
        @(negedge clk);
        chk("R11", "idle after three words", 32'(nf_busy), 32'd0);

        // R1: reset in the middle of a transaction
        full_pat = 16'hFFFF;
        issue(1'b1, 2'd2, 32'h8000_0000, 32'h9);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        full_pat = 16'h0000;
        @(negedge clk);
        chk("R1", "busy after mid reset",   32'(busy),   32'd0);
        chk("R1", "out_wr after mid reset", 32'(out_wr), 32'd0);
        repeat (4) @(negedge clk);
        report();
    end

endmodule